// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor that retires one instruction on every clock edge. In one long cycle it fetches from its internal instruction array, decodes, reads two registers, runs the ALU, optionally touches its internal data array, and on the common rising edge updates the program counter, the register file and data memory together. The instruction set is kept to eight instructions: four arithmetic/logic register operations, a signed set-less-than, a word load, a word store and a branch on equality.

Decoding happens in two levels. The main decoder reads only the 6-bit opcode. It produces the datapath steering signals and a 2-bit ALU class. A second decoder combines that class with the low bits of the instruction to pick the 3-bit ALU operation.

Both memories are word arrays inside the core. A test environment fills them through a load port while reset is held. It then releases reset and lets the program run. The final register and data memory contents can be read through combinational peek ports.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and all registers become 0. The core makes no register or data-memory write in that cycle. After release, the first instruction executed is the word at byte address 0.
- R2: An R-format word (opcode 000000, shift field [10:6] zero) with function 100000, 100010, 100100 or 100101 writes rs+rt, rs-rt, rs AND rt or rs OR rt into rd. rs is taken from bits [25:21], rt from [20:16] and rd from [15:11]. Arithmetic wraps modulo 2^32.
- R3: An R-format word with function 101010 writes 1 into rd when rs is less than rt as signed two's-complement values, and writes 0 otherwise, including when rs equals rt.
- R4: Register 0 always reads as zero, and any write that targets it is discarded.
- R5: Opcode 100011 loads the data word at byte address rs + sign-extended imm[15:0] into rt. This includes negative offsets.
- R6: Opcode 101011 stores rt at byte address rs + sign-extended imm[15:0] and writes no register.
- R7: Opcode 000100 with rs equal to rt sets the PC to PC+4 + (sign-extended imm << 2). A negative offset can branch backwards or onto itself.
- R8: Opcode 000100 with rs not equal to rt sets the PC to PC+4. A branch never writes a register or data memory.
- R9: Every instruction other than a branch advances the PC by 4.
- R10: Any other opcode, and any R-format word whose function is not in R2/R3 or whose shift field is nonzero, writes neither a register nor data memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Current program counter (byte address) |
| load_imem_we | input | 1 | Load-port write strobe for the instruction array |
| load_imem_addr | input | IAW | Word index written in the instruction array |
| load_imem_data | input | 32 | Instruction word to write |
| load_dmem_we | input | 1 | Load-port write strobe for the data array |
| load_dmem_addr | input | DAW | Word index written in the data array |
| load_dmem_data | input | 32 | Data word to write |
| peek_dmem_addr | input | DAW | Word index of the data array to observe |
| peek_dmem_data | output | 32 | Combinational data-array contents at that index |
| peek_reg_addr | input | 5 | Register number to observe |
| peek_reg_data | output | 32 | Combinational register contents (0 for register 0) |

## Verification
On every cycle, the assertions check the decoder's write gating. Stores, branches and illegal words must never write a register. Branches and illegal words must never write memory, and loads and stores must force an add. The assertions also check that non-branch instructions step the PC by 4 and that register 0 always reads zero. Whether results are numerically right can only be shown by the bench's program, and the same holds for signed comparison at the overflow edge, effective addresses with negative offsets, taken versus skipped branch paths, and discarded writes to register 0. The bench runs that program over directed and random operand sets and compares the final architectural state with values it computes itself.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OPC_RFMT  = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        CLS_MEM  = 2'b00,
        CLS_BR   = 2'b01,
        CLS_RFMT = 2'b10,
        CLS_NONE = 2'b11
    } alu_cls_e;

    typedef struct packed {
        logic     known;
        logic     dst_rd;
        logic     src_imm;
        logic     wb_mem;
        logic     reg_wr;
        logic     mem_rd;
        logic     mem_wr;
        logic     branch;
        alu_cls_e cls;
    } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{known: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0,
                 reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0, branch: 1'b0,
                 cls: CLS_NONE};
        unique case (opcode)
            OPC_RFMT: begin
                ctrl.known  = 1'b1;
                ctrl.dst_rd = 1'b1;
                ctrl.reg_wr = 1'b1;
                ctrl.cls    = CLS_RFMT;
            end
            OPC_LOAD: begin
                ctrl.known   = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.mem_rd  = 1'b1;
                ctrl.cls     = CLS_MEM;
            end
            OPC_STORE: begin
                ctrl.known   = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
                ctrl.cls     = CLS_MEM;
            end
            OPC_BEQ: begin
                ctrl.known  = 1'b1;
                ctrl.branch = 1'b1;
                ctrl.cls    = CLS_BR;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_pkg::*;
(
    input  alu_cls_e    cls,
    input  logic [10:0] low_bits,
    output alu_fn_e     fn,
    output logic        fn_ok
);
    logic [5:0] funct;
    logic [4:0] shamt;
    assign funct = low_bits[5:0];
    assign shamt = low_bits[10:6];

    always_comb begin
        fn    = ALU_ADD;
        fn_ok = 1'b1;
        unique case (cls)
            CLS_MEM: fn = ALU_ADD;
            CLS_BR:  fn = ALU_SUB;
            CLS_RFMT: begin
                fn_ok = (shamt == 5'd0);
                unique case (funct)
                    FN_ADD:  fn = ALU_ADD;
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn_ok = 1'b0;
                endcase
            end
            default: fn_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    parameter int NRD  = 3,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);
    logic [NREG-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && (waddr != '0)) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : regs_q[raddr[g]];
    end
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
    parameter int WORDS = 64,
    parameter int W     = 32,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic                   clk,
    input  logic                   ld_we,
    input  logic [AW-1:0]          ld_addr,
    input  logic [W-1:0]           ld_data,
    input  logic                   core_we,
    input  logic [AW-1:0]          core_addr,
    input  logic [W-1:0]           core_data,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output logic [NRD-1:0][W-1:0]  rdata
);
    logic [W-1:0] mem_d [WORDS];
    logic [W-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (ld_we) begin
            mem_d[ld_addr] = ld_data;
        end
        if (core_we) begin
            mem_d[core_addr] = core_data;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem_q[raddr[g]];
    end
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [31:0]     pc_o,
    input  logic            load_imem_we,
    input  logic [IAW-1:0]  load_imem_addr,
    input  logic [31:0]     load_imem_data,
    input  logic            load_dmem_we,
    input  logic [DAW-1:0]  load_dmem_addr,
    input  logic [31:0]     load_dmem_data,
    input  logic [DAW-1:0]  peek_dmem_addr,
    output logic [31:0]     peek_dmem_data,
    input  logic [4:0]      peek_reg_addr,
    output logic [31:0]     peek_reg_data
);
    localparam int RAW = 5;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] instr;
    ctrl_t           ctrl;
    alu_fn_e         alu_ctl;
    logic            fn_ok;
    logic            legal;
    logic            rf_we;
    logic            dm_we;
    logic [RAW-1:0]  wr_addr;
    logic [XLEN-1:0] wr_data;
    logic [XLEN-1:0] rs_val, rt_val;
    logic [XLEN-1:0] imm_se;
    logic [XLEN-1:0] alu_b, alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] dm_rdata, dm_load;
    logic [XLEN-1:0] pc_plus4, br_target;

    logic [0:0][IAW-1:0]        im_raddr;
    logic [0:0][XLEN-1:0]       im_rdata;
    logic [1:0][DAW-1:0]        dm_raddr;
    logic [1:0][XLEN-1:0]       dm_rdata_v;
    logic [2:0][RAW-1:0]        rf_raddr;
    logic [2:0][XLEN-1:0]       rf_rdata;

    assign pc_q = st_q.pc;
    assign pc_o = pc_q;

    // Instruction fetch
    assign im_raddr[0] = pc_q[IAW+1:2];
    sc_mem #(.WORDS(IMEM_WORDS), .W(XLEN), .NRD(1)) u_imem (
        .clk       (clk),
        .ld_we     (load_imem_we),
        .ld_addr   (load_imem_addr),
        .ld_data   (load_imem_data),
        .core_we   (1'b0),
        .core_addr ('0),
        .core_data ('0),
        .raddr     (im_raddr),
        .rdata     (im_rdata)
    );
    assign instr = im_rdata[0];

    // Two-level decode
    sc_main_dec u_main_dec (
        .opcode (instr[31:26]),
        .ctrl   (ctrl)
    );

    sc_alu_dec u_alu_dec (
        .cls      (ctrl.cls),
        .low_bits (instr[10:0]),
        .fn       (alu_ctl),
        .fn_ok    (fn_ok)
    );

    assign legal = ctrl.known && fn_ok;
    assign rf_we = ctrl.reg_wr && legal && !rst;
    assign dm_we = ctrl.mem_wr && legal && !rst;

    // Register file: port 0 = rs, port 1 = rt, port 2 = observation
    assign rf_raddr[0] = instr[25:21];
    assign rf_raddr[1] = instr[20:16];
    assign rf_raddr[2] = peek_reg_addr;
    assign wr_addr     = ctrl.dst_rd ? instr[15:11] : instr[20:16];

    sc_regfile #(.NREG(32), .W(XLEN), .NRD(3)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );
    assign rs_val        = rf_rdata[0];
    assign rt_val        = rf_rdata[1];
    assign peek_reg_data = rf_rdata[2];

    // Execute
    assign imm_se = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign alu_b  = ctrl.src_imm ? imm_se : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (alu_ctl),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data memory: port 0 = core load, port 1 = observation
    assign dm_raddr[0] = alu_y[DAW+1:2];
    assign dm_raddr[1] = peek_dmem_addr;

    sc_mem #(.WORDS(DMEM_WORDS), .W(XLEN), .NRD(2)) u_dmem (
        .clk       (clk),
        .ld_we     (load_dmem_we),
        .ld_addr   (load_dmem_addr),
        .ld_data   (load_dmem_data),
        .core_we   (dm_we),
        .core_addr (alu_y[DAW+1:2]),
        .core_data (rt_val),
        .raddr     (dm_raddr),
        .rdata     (dm_rdata_v)
    );
    assign dm_rdata       = dm_rdata_v[0];
    assign peek_dmem_data = dm_rdata_v[1];

    assign dm_load = ctrl.mem_rd ? dm_rdata : '0;
    assign wr_data = ctrl.wb_mem ? dm_load : alu_y;

    // Next PC
    assign pc_plus4  = pc_q + 32'd4;
    assign br_target = pc_plus4 + {imm_se[XLEN-3:0], 2'b00};

    always_comb begin
        st_d    = st_q;
        st_d.pc = (ctrl.branch && alu_zero) ? br_target : pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        rf_we,
    input logic        dm_we,
    input alu_fn_e     alu_ctl,
    input logic [4:0]  peek_reg_addr,
    input logic [31:0] peek_reg_data
);
    logic [5:0] op;
    logic       op_known;
    assign op       = instr[31:26];
    assign op_known = (op == OPC_RFMT) || (op == OPC_LOAD) ||
                      (op == OPC_STORE) || (op == OPC_BEQ);

    p_zero_reg_r4: assert property (@(posedge clk) disable iff (rst)
        (peek_reg_addr == 5'd0) |-> (peek_reg_data == 32'd0));

    p_load_add_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_LOAD) |-> (alu_ctl == ALU_ADD) && !dm_we);

    p_store_noreg_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_STORE) |-> !rf_we && dm_we && (alu_ctl == ALU_ADD));

    p_branch_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BEQ) |-> !rf_we && !dm_we && (alu_ctl == ALU_SUB));

    p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
        (op != OPC_BEQ) |=> (pc == $past(pc) + 32'd4));

    p_unknown_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !op_known |-> !rf_we && !dm_we);
endmodule

bind sc_core sc_core_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .pc            (pc_q),
    .instr         (instr),
    .rf_we         (rf_we),
    .dm_we         (dm_we),
    .alu_ctl       (alu_ctl),
    .peek_reg_addr (peek_reg_addr),
    .peek_reg_data (peek_reg_data)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
    localparam int IAW = 6;
    localparam int DAW = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [31:0]    pc_o;
    logic           load_imem_we = 1'b0;
    logic [IAW-1:0] load_imem_addr = '0;
    logic [31:0]    load_imem_data = '0;
    logic           load_dmem_we = 1'b0;
    logic [DAW-1:0] load_dmem_addr = '0;
    logic [31:0]    load_dmem_data = '0;
    logic [DAW-1:0] peek_dmem_addr = '0;
    logic [31:0]    peek_dmem_data;
    logic [4:0]     peek_reg_addr = '0;
    logic [31:0]    peek_reg_data;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    sc_core dut_i (
        .clk            (clk),
        .rst            (rst),
        .pc_o           (pc_o),
        .load_imem_we   (load_imem_we),
        .load_imem_addr (load_imem_addr),
        .load_imem_data (load_imem_data),
        .load_dmem_we   (load_dmem_we),
        .load_dmem_addr (load_dmem_addr),
        .load_dmem_data (load_dmem_data),
        .peek_dmem_addr (peek_dmem_addr),
        .peek_dmem_data (peek_dmem_data),
        .peek_reg_addr  (peek_reg_addr),
        .peek_reg_data  (peek_reg_data)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] exp_slt(input logic [31:0] a, input logic [31:0] b);
        return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_is(input string req, input int r, input logic [31:0] exp);
        peek_reg_addr = 5'(r);
        #1;
        check(req, $sformatf("r%0d", r), peek_reg_data, exp);
    endtask

    task automatic mem_is(input string req, input int w, input logic [31:0] exp);
        peek_dmem_addr = DAW'(w);
        #1;
        check(req, $sformatf("mem[%0d]", w), peek_dmem_data, exp);
    endtask

    task automatic load_i(input int idx, input logic [31:0] word);
        @(negedge clk);
        load_imem_we = 1'b1; load_imem_addr = IAW'(idx); load_imem_data = word;
        @(negedge clk);
        load_imem_we = 1'b0;
    endtask

    task automatic load_d(input int idx, input logic [31:0] word);
        @(negedge clk);
        load_dmem_we = 1'b1; load_dmem_addr = DAW'(idx); load_dmem_data = word;
        @(negedge clk);
        load_dmem_we = 1'b0;
    endtask

    task automatic load_program();
        load_i(0,  enc_i(6'b100011, 0, 1, 0));
        load_i(1,  enc_i(6'b100011, 0, 2, 4));
        load_i(2,  enc_i(6'b100011, 0, 3, 8));
        load_i(3,  enc_i(6'b100011, 0, 12, 12));
        load_i(4,  enc_r(1, 2, 4,  6'b100000));
        load_i(5,  enc_r(1, 2, 5,  6'b100010));
        load_i(6,  enc_r(1, 2, 6,  6'b100100));
        load_i(7,  enc_r(1, 2, 7,  6'b100101));
        load_i(8,  enc_r(1, 2, 8,  6'b101010));
        load_i(9,  enc_r(2, 1, 9,  6'b101010));
        load_i(10, enc_r(1, 1, 15, 6'b101010));
        load_i(11, enc_r(3, 1, 16, 6'b101010));
        load_i(12, enc_r(1, 2, 0,  6'b100000));
        load_i(13, enc_i(6'b101011, 0, 4, 16));
        load_i(14, enc_i(6'b101011, 12, 5, 4));
        load_i(15, enc_i(6'b000100, 1, 1, 2));
        load_i(16, enc_r(1, 1, 13, 6'b100000));
        load_i(17, enc_r(2, 2, 13, 6'b100000));
        load_i(18, enc_i(6'b000100, 1, 2, 1));
        load_i(19, enc_i(6'b111111, 0, 19, 0));
        load_i(20, enc_r(1, 2, 17, 6'b000111));
        load_i(21, enc_i(6'b100011, 12, 18, -4));
        load_i(22, enc_r(3, 0, 14, 6'b100000));
        load_i(23, enc_i(6'b000100, 0, 0, -1));
    endtask

    task automatic run_case(input int k, input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] c, input logic [31:0] d5);
        rst = 1'b1;
        load_d(0, a);
        load_d(1, b);
        load_d(2, c);
        load_d(3, 32'd20);
        load_d(4, 32'h0);
        load_d(5, d5);
        load_d(6, 32'h0);
        @(negedge clk);
        // R1: reset state, registers cleared and PC at zero
        check("R1", "pc in reset", pc_o, 32'd0);
        reg_is("R1", 4, 32'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R9: first instruction (load) advances PC by 4
        check("R9", "pc after first step", pc_o, 32'd4);
        repeat (40) @(negedge clk);
        // R7: backward branch onto itself holds PC at word 23
        check("R7", "halt pc", pc_o, 32'd92);
        @(negedge clk);
        check("R7", "halt pc stable", pc_o, 32'd92);
        reg_is("R5", 1, a);
        reg_is("R5", 2, b);
        reg_is("R5", 12, 32'd20);
        reg_is("R2", 4, a + b);
        reg_is("R2", 5, a - b);
        reg_is("R2", 6, a & b);
        reg_is("R2", 7, a | b);
        reg_is("R3", 8, exp_slt(a, b));
        reg_is("R3", 9, exp_slt(b, a));
        reg_is("R3", 15, 32'd0);
        reg_is("R3", 16, exp_slt(c, a));
        reg_is("R4", 0, 32'd0);
        mem_is("R6", 4, a + b);
        mem_is("R6", 6, a - b);
        mem_is("R6", 5, d5);
        mem_is("R6", 0, a);
        reg_is("R7", 13, 32'd0);
        reg_is("R8", 14, c);
        reg_is("R10", 19, 32'd0);
        reg_is("R10", 17, 32'd0);
        reg_is("R5", 18, a + b);
        $display("case %0d done", k);
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (2) @(negedge clk);
        load_program();
        // directed corners: signed overflow edge and all-ones vs zero
        run_case(0, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0000, 32'hDEAD_BEEF);
        run_case(1, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678);
        for (int i = 2; i < 8; i++) begin
            logic [31:0] a, b, c, d5, flip;
            a    = $urandom();
            flip = $urandom() | 32'd1;
            b    = a ^ flip;
            c    = $urandom();
            d5   = $urandom();
            run_case(i, a, b, c, d5);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule